// File: doc/BRIEF.md
# Dual Non-Retriggerable One-Shot

This block holds two independent one-shot pulse generators that run from a single clock. Each channel has three inputs: a trigger that acts on its rising edge, an active-low enable for that trigger, and an active-low clear. Each channel drives a pulse output and its inverse. A qualified trigger edge starts a pulse whose length is a per-channel parameter given in clock cycles. A down-counter then times the pulse out, and it ends without further input.

A trigger that arrives while a pulse is already running is dropped. The pulse is neither restarted nor stretched. All inputs may be asynchronous to the clock, so they pass through a synchroniser before any decision is made. The block suits strobe stretching, watchdog-style lockout windows and fixed-length enables, where a burst of triggers must give a single pulse of known length.

Top module: `dual_oneshot`

## Requirements
- R1: While `rst` is high and on the first edge after it, `pulse` is 0 and `pulse_n` is all ones.
- R2: On every channel, `pulse_n` is the bitwise inverse of `pulse` at every clock edge after the first one, including during reset.
- R3: A 0-to-1 change on `trig_hi[i]`, made while `trig_lo_n[i]` is 0 and `clr_n[i]` is 1, sets `pulse[i]` on the third rising clock edge after the input change (two synchroniser stages plus one output register).
- R4: Unless a clear cuts it short, a pulse stays high for exactly `PULSE_CYC_A` cycles on channel 0 and `PULSE_CYC_B` cycles on channel 1 (defaults 1000 and 900).
- R5: No pulse starts when `trig_hi[i]` rises while `trig_lo_n[i]` is 1. No pulse starts when `trig_lo_n[i]` falls while `trig_hi[i]` is already high.
- R6: A qualified trigger whose edge is seen while a pulse is running has no effect, even in the last high cycle of that pulse. The pulse ends in the cycle set by its own start.
- R7: A qualified trigger edge seen in the first cycle after a pulse ends starts a new pulse, which leaves a low gap of exactly one cycle.
- R8: Driving `clr_n[i]` low clears `pulse[i]` on the third rising clock edge after the input change. While the clear stays low, trigger edges start nothing.
- R9: The channels are independent. A trigger, a clear or a running pulse on one channel does not change the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_lo_n | input | 2 | Active-low trigger enable, one bit per channel |
| trig_hi | input | 2 | Rising-edge trigger, one bit per channel |
| clr_n | input | 2 | Active-low clear, one bit per channel |
| pulse | output | 2 | Pulse output, one bit per channel |
| pulse_n | output | 2 | Inverse of `pulse` |

## Verification
A single trigger on both channels together separates the two configured widths and shows the three-cycle start latency. Triggers placed during a running pulse, in the last high cycle and in the first low cycle separate a non-retriggerable counter from one that reloads or that misses the boundary cycle. Triggers made with the enable high, or made by moving the enable instead of the trigger input, show that the edge is taken only from the trigger input. A clear in the middle of a pulse, followed by a trigger while the clear is still low, separates a clear that only stops the counter from one that also blocks new pulses.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  localparam int unsigned OS_CHANNELS = 2;

  // Synchronised view of one channel's inputs
  typedef struct packed {
    logic hi;     // rising-edge trigger
    logic lo_n;   // active-low trigger enable
    logic clr_n;  // active-low clear
  } os_trig_t;

  // Reset value of the synchroniser: no trigger, enable off, clear held
  localparam os_trig_t OS_TRIG_RST = '{hi: 1'b0, lo_n: 1'b1, clr_n: 1'b0};

  // Bits needed to hold the values 0 .. n-1
  function automatic int unsigned os_cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  os_trig_t sin,
  output logic     fire,
  output logic     clr_ok
);

  logic hi_prev;

  always_ff @(posedge clk) begin
    if (rst) hi_prev <= 1'b0;
    else     hi_prev <= sin.hi;
  end

  // Edge on the trigger only; the enable level and clear gate it
  assign fire   = sin.hi & ~hi_prev & ~sin.lo_n & sin.clr_n;
  assign clr_ok = sin.clr_n;

endmodule

// File: rtl/os_timer.sv
module os_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic clr_ok,
  output logic pulse,
  output logic pulse_n
);

  localparam int unsigned CW = os_cnt_bits(PULSE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          inv_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (!clr_ok) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      // running: triggers are ignored here
      if (cnt_q == '0) active_d = 1'b0;
      else             cnt_d    = cnt_q - 1'b1;
    end else if (fire) begin
      active_d = 1'b1;
      cnt_d    = LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      inv_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      inv_q    <= ~active_d;
    end
  end

  assign pulse   = active_q;
  assign pulse_n = inv_q;

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned PULSE_CYC_A = 1000,
  parameter int unsigned PULSE_CYC_B = 900,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] trig_lo_n,
  input  logic [1:0] trig_hi,
  input  logic [1:0] clr_n,
  output logic [1:0] pulse,
  output logic [1:0] pulse_n
);

  logic [OS_CHANNELS-1:0] fire_w;
  logic [OS_CHANNELS-1:0] clr_w;

  for (genvar g = 0; g < OS_CHANNELS; g++) begin : g_ch
    localparam int unsigned WIDTH_CYC = (g == 0) ? PULSE_CYC_A : PULSE_CYC_B;

    os_trig_t raw, synced;

    assign raw = '{hi: trig_hi[g], lo_n: trig_lo_n[g], clr_n: clr_n[g]};

    os_sync #(
      .WIDTH  ($bits(os_trig_t)),
      .STAGES (SYNC_STAGES),
      .RST_VAL(OS_TRIG_RST)
    ) sync_i (
      .clk(clk),
      .rst(rst),
      .d  (raw),
      .q  (synced)
    );

    os_edge_qual qual_i (
      .clk   (clk),
      .rst   (rst),
      .sin   (synced),
      .fire  (fire_w[g]),
      .clr_ok(clr_w[g])
    );

    os_timer #(
      .PULSE_CYC(WIDTH_CYC)
    ) timer_i (
      .clk    (clk),
      .rst    (rst),
      .fire   (fire_w[g]),
      .clr_ok (clr_w[g]),
      .pulse  (pulse[g]),
      .pulse_n(pulse_n[g])
    );
  end

endmodule

// File: rtl/dual_oneshot_chk.sv
module dual_oneshot_chk #(
  parameter int unsigned PULSE_CYC_A = 1000,
  parameter int unsigned PULSE_CYC_B = 900
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pulse,
  input logic [1:0] pulse_n,
  input logic [1:0] fire_w,
  input logic [1:0] clr_w
);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    localparam int unsigned W = (g == 0) ? PULSE_CYC_A : PULSE_CYC_B;

    int unsigned hi_len;

    // Number of consecutive cycles the pulse has been high so far
    always_ff @(posedge clk) begin
      if (rst)           hi_len <= 0;
      else if (pulse[g]) hi_len <= hi_len + 1;
      else               hi_len <= 0;
    end

    assert_complement_R2: assert property (@(posedge clk) disable iff (rst)
      pulse_n[g] == ~pulse[g]);

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
      fire_w[g] && !pulse[g] |=> pulse[g]);

    assert_full_width_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse[g]) && $past(clr_w[g]) |-> hi_len == W);

    assert_no_stretch_R6: assert property (@(posedge clk) disable iff (rst)
      pulse[g] |-> hi_len < W);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      !clr_w[g] |=> !pulse[g]);
  end

endmodule

bind dual_oneshot dual_oneshot_chk #(
  .PULSE_CYC_A(PULSE_CYC_A),
  .PULSE_CYC_B(PULSE_CYC_B)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .pulse  (pulse),
  .pulse_n(pulse_n),
  .fire_w (fire_w),
  .clr_w  (clr_w)
);

// File: tb/dual_oneshot_tb_top.sv
module dual_oneshot_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  W0 = 1000;
  localparam int  W1 = 900;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst;
  logic [1:0] trig_lo_n, trig_hi, clr_n;
  logic [1:0] pulse, pulse_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int comp_err = 0;
  int rise_cnt  [2] = '{0, 0};
  int last_rise [2] = '{0, 0};
  int last_fall [2] = '{0, 0};
  logic [1:0] prev_p = 2'b00;

  dual_oneshot #(
    .PULSE_CYC_A(W0),
    .PULSE_CYC_B(W1)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .trig_lo_n(trig_lo_n),
    .trig_hi  (trig_hi),
    .clr_n    (clr_n),
    .pulse    (pulse),
    .pulse_n  (pulse_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Edge recorder, sampled away from the active edge
  always @(negedge clk) begin
    if (cyc > 0 && pulse_n !== ~pulse) comp_err = comp_err + 1;
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        if (pulse[c] !== prev_p[c]) begin
          if (pulse[c]) begin
            rise_cnt[c]  = rise_cnt[c] + 1;
            last_rise[c] = cyc;
          end else begin
            last_fall[c] = cyc;
          end
        end
      end
    end
    prev_p = pulse;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Raise the trigger at a negedge for three cycles; n is the cycle count then
  task automatic pulse_hi(input int ch, output int n);
    n = cyc;
    trig_hi[ch] = 1'b1;
    repeat (3) @(negedge clk);
    trig_hi[ch] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pulse in reset", int'(pulse), 0);
    chk("R1", "pulse_n in reset", int'(pulse_n), 3);
    @(negedge clk);
    chk("R1", "pulse in reset 2nd cycle", int'(pulse), 0);
    chk("R2", "pulse_n in reset 2nd cycle", int'(pulse_n), 3);
  endtask

  task automatic t_basic();
    int n0, n1, b0, b1;
    b0 = rise_cnt[0];
    b1 = rise_cnt[1];
    fork
      pulse_hi(0, n0);
      pulse_hi(1, n1);
    join
    wait_cyc(n0 + 3 + W0 + 5);
    chk("R3", "ch0 rise cycle", last_rise[0], n0 + 3);
    chk("R3", "ch1 rise cycle", last_rise[1], n1 + 3);
    chk("R4", "ch0 width", last_fall[0] - last_rise[0], W0);
    chk("R4", "ch1 width", last_fall[1] - last_rise[1], W1);
    chk("R9", "ch0 single pulse", rise_cnt[0] - b0, 1);
    chk("R9", "ch1 single pulse", rise_cnt[1] - b1, 1);
  endtask

  task automatic t_gate();
    int n, b;
    b = rise_cnt[0];
    trig_lo_n[0] = 1'b1;
    pulse_hi(0, n);
    idle(20);
    chk("R5", "trigger with enable high", rise_cnt[0] - b, 0);
    trig_hi[0] = 1'b1;
    idle(5);
    trig_lo_n[0] = 1'b0;
    idle(20);
    chk("R5", "enable falling under high trigger", rise_cnt[0] - b, 0);
    trig_hi[0] = 1'b0;
    idle(5);
  endtask

  task automatic t_retrig();
    int n, m, b, b1;
    b  = rise_cnt[0];
    b1 = rise_cnt[1];
    pulse_hi(0, n);
    wait_cyc(n + 100);
    pulse_hi(0, m);
    wait_cyc(n + 3 + W0 + 10);
    chk("R6", "retrigger mid-pulse rises", rise_cnt[0] - b, 1);
    chk("R6", "retrigger mid-pulse end", last_fall[0], n + 3 + W0);
    chk("R9", "ch1 untouched by ch0", rise_cnt[1] - b1, 0);
  endtask

  task automatic t_boundary();
    int n, m, b;
    // Trigger edge seen in the last high cycle
    b = rise_cnt[0];
    pulse_hi(0, n);
    wait_cyc(n + W0);
    pulse_hi(0, m);
    wait_cyc(n + W0 + 15);
    chk("R6", "last-cycle trigger rises", rise_cnt[0] - b, 1);
    chk("R6", "last-cycle trigger end", last_fall[0], n + 3 + W0);
    idle(10);
    // Trigger edge seen in the first low cycle
    b = rise_cnt[0];
    pulse_hi(0, n);
    wait_cyc(n + W0 + 1);
    pulse_hi(0, m);
    wait_cyc(n + W0 + 6);
    chk("R7", "first-low-cycle trigger rises", rise_cnt[0] - b, 2);
    chk("R7", "first pulse end", last_fall[0], n + 3 + W0);
    chk("R7", "second pulse start", last_rise[0], n + 4 + W0);
    wait_cyc(n + 4 + 2 * W0 + 5);
    chk("R7", "second pulse width", last_fall[0] - last_rise[0], W0);
  endtask

  task automatic t_clear();
    int n, m, k, b;
    b = rise_cnt[0];
    pulse_hi(0, n);
    wait_cyc(n + 50);
    clr_n[0] = 1'b0;
    m = cyc;
    wait_cyc(m + 10);
    chk("R8", "clear ends pulse", last_fall[0], m + 3);
    pulse_hi(0, k);
    idle(20);
    chk("R8", "trigger blocked under clear", rise_cnt[0] - b, 1);
    clr_n[0] = 1'b1;
    idle(5);
    pulse_hi(0, k);
    wait_cyc(k + 10);
    chk("R8", "trigger after clear release", last_rise[0], k + 3);
    wait_cyc(k + 3 + W0 + 5);
    chk("R4", "width after clear release", last_fall[0] - last_rise[0], W0);
  endtask

  initial begin
    rst       = 1'b1;
    trig_lo_n = 2'b00;
    trig_hi   = 2'b00;
    clr_n     = 2'b11;
    t_reset();
    rst = 1'b0;
    idle(5);
    t_basic();
    t_gate();
    t_retrig();
    t_boundary();
    t_clear();
    chk("R2", "complement mismatches", comp_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1-through-R9 run: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule